// File: doc/BRIEF.md
# Sync Header Error Injector for a 66-bit Block Stream

This block sits on the transmit side of a 64b/66b link, after the encoder and before the gearbox. It takes one 66-bit block per handshake, made of a 2-bit sync header and a data payload. On request, it damages the sync header of exactly one block so that the receiver at the far end sees a block with an invalid header. A valid header is changed into the invalid code of the same leading bit. The control header 01 becomes 00, and the data header 10 becomes 11. The payload always passes through unchanged.

A request comes from either of two sources. One is a rising edge on a configuration bit. The other is a rising edge on an external request pin. A request takes effect only while the static enable is high. A request that cannot be applied at once is kept pending until the next accepted block. Several requests that arrive before that block are merged into one. Each damaged block is marked by a strobe on the output side. A saturating counter keeps the number of injections.

Both stream sides use valid/ready. A block is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output block is held. The data path always has one register stage, whether injection is enabled or not.

Top module: `sync_hdr_err_inj`

## Requirements
- R1: When a request applies to an accepted block with header 2'b01, that block leaves with header 2'b00 and an unchanged payload.
- R2: When a request applies to an accepted block with header 2'b10, that block leaves with header 2'b11 and an unchanged payload.
- R3: When a request applies to a block whose header is already 2'b00 or 2'b11, the header passes unchanged, no strobe or count results, and the request is consumed.
- R4: No block is altered while `cfg_enable` is low. A request that arrives while it is low is dropped. A pending request is discarded when it goes low.
- R5: Only a 0-to-1 transition of `cfg_trig` makes a request. Holding it high alters no further blocks.
- R6: A 0-to-1 transition of `err_req_pin` makes a request with the same effect. A level held through reset makes no request.
- R7: A request in a cycle with no accepted block, whether the input is idle or stalled, is applied to the next accepted block only.
- R8: Requests that arrive while one is already pending merge, so exactly one block is altered for them.
- R9: An accepted block appears at the output one clock later. `in_ready` equals `!out_valid || out_ready`. A stalled output block stays stable.
- R10: `inj_strobe` is high exactly while an altered block is presented on the output.
- R11: `inj_count` rises by one for each altered block, together with its strobe, and saturates at all ones.
- R12: Synchronous reset clears `out_valid`, `inj_strobe`, `inj_count` and any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Static injection enable |
| cfg_trig | input | 1 | Configuration trigger bit; its rising edge requests an injection |
| err_req_pin | input | 1 | External request pin; its rising edge requests an injection |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Input block ready |
| in_hdr | input | 2 | Input sync header |
| in_data | input | DATA_W | Input payload |
| out_valid | output | 1 | Output block valid |
| out_ready | input | 1 | Output block ready |
| out_hdr | output | 2 | Output sync header, possibly altered |
| out_data | output | DATA_W | Output payload |
| inj_strobe | output | 1 | High while the presented block was altered |
| inj_count | output | CNT_W | Saturating count of altered blocks |

## Verification
The hardest cases to reach from the ports are those where the request and the block it targets are not in the same cycle. These are a request raised while the output is stalled, two requests merged before any block arrives, and a pending request that is cancelled by dropping the enable. The stimulus reaches these cases in three ways: it inserts idle cycles, it holds `out_ready` low across a request edge, and it changes the enable between the request and the block. A sweep covers every header code, both enable values and each request source. After each request, the next block is checked to confirm that exactly one block was altered. A reduced counter width lets the bench reach saturation.

// File: rtl/shi_pkg.sv
package shi_pkg;
  localparam logic [1:0] HDR_CTRL = 2'b01;
  localparam logic [1:0] HDR_DATA = 2'b10;

  function automatic logic hdr_is_valid(input logic [1:0] h);
    return (h == HDR_CTRL) || (h == HDR_DATA);
  endfunction

  // Valid header -> invalid code with the same leading bit; invalid codes unchanged.
  function automatic logic [1:0] hdr_break(input logic [1:0] h);
    if (hdr_is_valid(h)) return {h[1], h[1]};
    return h;
  endfunction
endpackage

// File: rtl/shi_rise_det.sv
module shi_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic [N-1:0] sig,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // prev follows the level even in reset, so a level held high is never an edge.
    always_ff @(posedge clk) prev[i] <= sig[i];
    assign rise[i] = sig[i] & ~prev[i];
  end
endmodule

// File: rtl/shi_req_track.sv
module shi_req_track (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic flag,
  input  logic take,
  output logic apply
);
  logic pend_q;

  assign apply = take & enable & (pend_q | flag);

  always_ff @(posedge clk) begin
    if (rst || !enable || apply) pend_q <= 1'b0;
    else if (flag)               pend_q <= 1'b1;
  end
endmodule

// File: rtl/shi_sat_cnt.sv
module shi_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                      count <= '0;
    else if (inc && count != MAX) count <= count + 1'b1;
  end
endmodule

// File: rtl/sync_hdr_err_inj.sv
module sync_hdr_err_inj #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_trig,
  input  logic              err_req_pin,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_hdr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_hdr,
  output logic [DATA_W-1:0] out_data,
  output logic              inj_strobe,
  output logic [CNT_W-1:0]  inj_count
);
  import shi_pkg::*;

  localparam int NSRC = 2;

  logic [NSRC-1:0] src_lvl, src_rise;
  logic            take, apply, hit, out_mark;
  logic [1:0]      hdr_next;

  assign src_lvl = {err_req_pin, cfg_trig};

  shi_rise_det #(.N(NSRC)) u_rise (
    .clk  (clk),
    .sig  (src_lvl),
    .rise (src_rise)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  shi_req_track u_req (
    .clk    (clk),
    .rst    (rst),
    .enable (cfg_enable),
    .flag   (|src_rise),
    .take   (take),
    .apply  (apply)
  );

  always_comb begin
    hdr_next = apply ? hdr_break(in_hdr) : in_hdr;
    hit      = apply && hdr_is_valid(in_hdr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mark  <= 1'b0;
      out_hdr   <= '0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      out_mark  <= hit;
      if (in_valid) begin
        out_hdr  <= hdr_next;
        out_data <= in_data;
      end
    end
  end

  assign inj_strobe = out_valid && out_mark;

  shi_sat_cnt #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (hit),
    .count (inj_count)
  );
endmodule

// File: rtl/sync_hdr_err_inj_chk.sv
module sync_hdr_err_inj_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_enable,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_hdr,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_hdr,
  input logic [DATA_W-1:0] out_data,
  input logic              inj_strobe,
  input logic [CNT_W-1:0]  inj_count
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_hdr) && $stable(out_data)); // R9

  AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data)); // R9

  AST_STROBE_VALID: assert property (@(posedge clk) disable iff (rst)
    inj_strobe |-> out_valid && (out_hdr == 2'b00 || out_hdr == 2'b11)); // R10

  AST_OFF_NO_INJ: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable && in_valid && in_ready |=> !inj_strobe); // R4

  AST_BAD_HDR_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (in_hdr == 2'b00 || in_hdr == 2'b11)
      |=> out_hdr == $past(in_hdr) && !inj_strobe); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    inj_count != $past(inj_count) |-> inj_strobe && inj_count == $past(inj_count) + 1'b1); // R11
endmodule

bind sync_hdr_err_inj sync_hdr_err_inj_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_enable (cfg_enable),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_hdr     (in_hdr),
  .in_data    (in_data),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_hdr    (out_hdr),
  .out_data   (out_data),
  .inj_strobe (inj_strobe),
  .inj_count  (inj_count)
);

// File: tb/test_sync_hdr_err_inj.sv
module test_sync_hdr_err_inj;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst = 1;
  logic cfg_enable = 0, cfg_trig = 0, err_req_pin = 0;
  logic in_valid = 0, out_ready = 1;
  logic [1:0] in_hdr = 0;
  logic [DW-1:0] in_data = 0;
  logic in_ready, out_valid, inj_strobe;
  logic [1:0] out_hdr;
  logic [DW-1:0] out_data;
  logic [CW-1:0] inj_count;

  int checks = 0, errors = 0, exp_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_hdr_err_inj #(.DATA_W(DW), .CNT_W(CW)) i_sync_hdr_err_inj (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_trig(cfg_trig),
    .err_req_pin(err_req_pin), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_hdr(out_hdr), .out_data(out_data), .inj_strobe(inj_strobe), .inj_count(inj_count));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a negedge, let one posedge pass, return at the next negedge.
  task automatic cyc(input logic v, input logic [1:0] h, input logic [DW-1:0] d,
                     input logic trg, input logic pin);
    in_valid = v; in_hdr = h; in_data = d; cfg_trig = trg; err_req_pin = pin;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_blk(input string req, input logic [1:0] eh, input logic [DW-1:0] d,
                         input logic es);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " hdr"}, int'(out_hdr), int'(eh));
    chk({req, " data"}, int'(out_data), int'(d));
    chk({req, " strobe"}, int'(inj_strobe), int'(es));
    if (es && exp_cnt < CMAX) exp_cnt++;
    chk({req, " count"}, int'(inj_count), exp_cnt);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    err_req_pin = 1; // R6: level held through reset is no edge
    repeat (3) @(negedge clk);
    rst = 0;
    cfg_enable = 1;
    chk("R12 out_valid", int'(out_valid), 0);
    chk("R12 strobe", int'(inj_strobe), 0);
    chk("R12 count", int'(inj_count), 0);
    chk("R9 in_ready idle", int'(in_ready), 1);
    cyc(1, 2'b01, 16'h1357, 0, 1);
    chk_blk("R6 held-through-reset", 2'b01, 16'h1357, 0);
    cyc(0, 2'b00, 0, 0, 0);

    // Sweep: enable x source x header code
    for (int en = 0; en < 2; en++)
      for (int src = 0; src < 3; src++)
        for (int h = 0; h < 4; h++) begin
          logic [1:0] hh = 2'(h);
          logic [DW-1:0] d = DW'(16'hA5C3 ^ (16'h1111 * (en * 12 + src * 4 + h)));
          logic hitx = (en == 1) && (src != 0) && (hh == 2'b01 || hh == 2'b10);
          string rq = (hh == 2'b01) ? "R1" : (hh == 2'b10) ? "R2" : "R3";
          cfg_enable = en[0];
          cyc(1, hh, d, src == 1, src == 2);
          if (en == 0) rq = "R4";
          chk_blk($sformatf("%s sweep en=%0d src=%0d", rq, en, src),
                  hitx ? {hh[1], hh[1]} : hh, d, hitx);
          // request source still high: next block untouched
          cyc(1, 2'b01, ~d, src == 1, src == 2);
          chk_blk(src == 2 ? "R6 held pin" : "R5 held trig", 2'b01, ~d, 0);
          cyc(0, 2'b00, 0, 0, 0);
          chk("R9 idle valid", int'(out_valid), 0);
        end
    cfg_enable = 1;

    // Pending across an idle cycle
    cyc(0, 2'b00, 0, 0, 1);
    chk("R7 idle valid", int'(out_valid), 0);
    chk("R7 idle strobe", int'(inj_strobe), 0);
    cyc(0, 2'b00, 0, 0, 0);
    cyc(1, 2'b10, 16'h0F0F, 0, 0);
    chk_blk("R7 pending applied", 2'b11, 16'h0F0F, 1);
    cyc(1, 2'b10, 16'hF0F0, 0, 0);
    chk_blk("R7 only one", 2'b10, 16'hF0F0, 0);

    // Merge: pin edge then trig edge, both before a block
    cyc(0, 2'b00, 0, 0, 1);
    cyc(0, 2'b00, 0, 1, 0);
    cyc(1, 2'b01, 16'h2222, 0, 0);
    chk_blk("R8 merged", 2'b00, 16'h2222, 1);
    cyc(1, 2'b01, 16'h3333, 0, 0);
    chk_blk("R8 second untouched", 2'b01, 16'h3333, 0);
    cyc(0, 2'b00, 0, 0, 0);

    // Pending cancelled by enable drop
    cyc(0, 2'b00, 0, 0, 1);
    cfg_enable = 0;
    cyc(0, 2'b00, 0, 0, 0);
    cfg_enable = 1;
    cyc(1, 2'b01, 16'h4444, 0, 0);
    chk_blk("R4 pending dropped", 2'b01, 16'h4444, 0);

    // Request during output stall
    cyc(1, 2'b01, 16'h5555, 0, 0);
    chk_blk("R9 pre-stall", 2'b01, 16'h5555, 0);
    out_ready = 0;
    cyc(1, 2'b10, 16'h6666, 0, 1);
    chk("R9 stall ready", int'(in_ready), 0);
    chk("R9 stall hdr", int'(out_hdr), 2'b01);
    chk("R9 stall data", int'(out_data), 16'h5555);
    chk("R10 stall strobe", int'(inj_strobe), 0);
    cyc(1, 2'b10, 16'h6666, 0, 0);
    chk("R9 stall hold", int'(out_data), 16'h5555);
    out_ready = 1;
    cyc(1, 2'b10, 16'h6666, 0, 0);
    chk_blk("R7 stalled request", 2'b11, 16'h6666, 1);
    cyc(1, 2'b10, 16'h7777, 0, 0);
    chk_blk("R7 after stall", 2'b10, 16'h7777, 0);
    cyc(0, 2'b00, 0, 0, 0);
    chk("R10 strobe cleared", int'(inj_strobe), 0);

    // Saturation
    for (int k = 0; k < CMAX + 3; k++) begin
      cyc(1, 2'b01, DW'(k), 0, 1);
      chk_blk("R11 saturate", 2'b00, DW'(k), 1);
      cyc(0, 2'b00, 0, 0, 0);
    end
    chk("R11 at max", int'(inj_count), CMAX);

    // Reset clears count
    rst = 1;
    cyc(0, 2'b00, 0, 0, 0);
    rst = 0;
    exp_cnt = 0;
    chk("R12 count cleared", int'(inj_count), 0);
    chk("R12 valid cleared", int'(out_valid), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule